// File: doc/BRIEF.md
# Vector-to-Polar Converter with Phase-Difference Frequency Output

This block turns a stream of baseband complex samples, given as 16-bit in-phase and quadrature words, into magnitude and phase words. It also derives a frequency word from the change in phase between one accepted sample and the next. A pipelined CORDIC in vectoring mode does the conversion. Before the first micro-rotation, a quadrant fold turns left-half-plane vectors by ±90°, so the whole circle is covered.

Phase is a signed 16-bit fraction of π, and the code that stands for +π is the same code as −π. The frequency word is a plain 16-bit modular difference, so it wraps correctly across the ±π seam. Two uses follow directly. Phase differences demodulate differential PSK, and the frequency word demodulates FM and FSK or drives an AFC loop. A first-order IIR smoother with a shift coefficient can be applied to the frequency word. A sample stream is accepted on every cycle in which the input valid is high, and gaps between samples are allowed.

Top module: `polar_disc`

## Requirements
- R1: For every accepted sample, `mag` lies within 3 LSB of sqrt(I²+Q²), as an unsigned 16-bit integer. The CORDIC gain is removed by a constant of about 0.6073.
- R2: `phase` lies within 3 LSB, modulo 2^16, of round(atan2(Q,I)/π·32768). It is two's complement, so +16384 is +90° and −32768 is ±180°.
- R3: The R2 accuracy holds in all four quadrants, on both axes, and for full-scale inputs including −32768. For example, (−A,0) gives a phase near −32768.
- R4: Every accepted sample yields exactly one `out_valid` pulse, 17 clock cycles after the edge that accepts it (that is, STAGES+1). Results come out in input order, and back-to-back input gives back-to-back output.
- R5: `freq_valid` pulses one cycle after each `out_valid` that has a predecessor. With `smooth_k`=0, `freq` equals the 16-bit wrapped difference between the current and the previous output phase.
- R6: After reset, the first phase output only captures a previous value and produces no `freq_valid`.
- R7: With smoothing, a state s (7 fraction bits, reset to 0) is updated on every frequency result as s ← s + ((d·128 − s) >>> k), where d is the wrapped difference. `freq` = s >>> 7 (floor), and k is `smooth_k`.
- R8: While `rst` is high, and after it, `out_valid` and `freq_valid` are low and `mag`, `phase` and `freq` are zero until new results arrive.
- R9: Cycles with `in_valid` low produce no output. The frequency difference is always taken between successive accepted samples, whatever the gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| smooth_k | input | 3 | Frequency smoothing shift, 0 = no smoothing |
| out_valid | output | 1 | Magnitude and phase qualifier |
| mag | output | 16 | Magnitude, unsigned |
| phase | output | 16 | Phase, signed fraction of π |
| freq_valid | output | 1 | Frequency qualifier |
| freq | output | 16 | Phase-difference frequency, signed |

## Verification
The assertions check the following on every cycle:
- after the quadrant fold, every vector lies in the right half-plane;
- no result appears without a sample in flight, and the number in flight never exceeds the pipeline depth;
- a frequency result only follows a phase result, and never before a previous phase has been captured.

Numeric accuracy of magnitude and phase cannot be checked cycle by cycle. Neither can the exact 17-cycle placement, wrap-around across ±π, the smoothing recurrence for several k values, or the handling of input gaps and a mid-run reset. Only the bench's scenarios show these, by comparing against ideal trigonometry and an independent recurrence model.

// File: rtl/polar_disc_pkg.sv
package polar_disc_pkg;

    localparam int DW    = 16;           // sample and result width
    localparam int GUARD = 2;            // fractional guard bits in x/y
    localparam int XW    = DW + GUARD + 3; // x/y datapath width (gain growth)
    localparam int AW    = DW + 4;       // angle accumulator, 2^(AW-1) = pi
    localparam int MAX_STAGES = 16;
    localparam logic [15:0] INV_GAIN = 16'd39797; // 0.60725 * 2^16

    typedef struct packed {
        logic                 valid;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [AW-1:0] z;
    } vec_t;

    // atan(2^-i)/pi scaled to 2^31, reduced to AW bits with rounding
    function automatic logic [AW-1:0] atan_step(input int i);
        logic [31:0] v;
        logic [31:0] r;
        case (i)
            0:  v = 32'd536870912;
            1:  v = 32'd316933406;
            2:  v = 32'd167458907;
            3:  v = 32'd85004756;
            4:  v = 32'd42667331;
            5:  v = 32'd21354465;
            6:  v = 32'd10679838;
            7:  v = 32'd5340245;
            8:  v = 32'd2670163;
            9:  v = 32'd1335087;
            10: v = 32'd667544;
            11: v = 32'd333772;
            12: v = 32'd166886;
            13: v = 32'd83443;
            14: v = 32'd41722;
            15: v = 32'd20861;
            default: v = 32'd0;
        endcase
        r = (v + (32'd1 << (31 - AW))) >> (32 - AW);
        return AW'(r);
    endfunction

endpackage

// File: rtl/cordic_vec.sv
module cordic_vec
    import polar_disc_pkg::*;
#(
    parameter int STAGES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_i,
    input  logic [DW-1:0]        in_q,
    output logic                 res_valid,
    output logic signed [XW-1:0] res_x,
    output logic signed [AW-1:0] res_z
);
    localparam logic signed [AW-1:0] QUARTER = AW'(1) <<< (AW - 2);

    vec_t st [0:STAGES];

    logic signed [XW-1:0] xi, yi;
    vec_t fold;

    always_comb begin
        xi = {{(XW-DW){in_i[DW-1]}}, in_i} <<< GUARD;
        yi = {{(XW-DW){in_q[DW-1]}}, in_q} <<< GUARD;
        fold.valid = in_valid;
        if (!xi[XW-1]) begin
            fold.x = xi;
            fold.y = yi;
            fold.z = '0;
        end else if (!yi[XW-1]) begin
            fold.x = yi;       // turn by -90 degrees
            fold.y = -xi;
            fold.z = QUARTER;
        end else begin
            fold.x = -yi;      // turn by +90 degrees
            fold.y = xi;
            fold.z = -QUARTER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= fold;
    end

    assert_fold_right_half_R3: assert property (@(posedge clk) disable iff (rst)
        st[0].valid |-> !st[0].x[XW-1]);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam logic signed [AW-1:0] ANG = atan_step(g);
        logic signed [XW-1:0] xs, ys;
        assign xs = st[g].x;
        assign ys = st[g].y;

        always_ff @(posedge clk) begin
            if (rst) begin
                st[g+1] <= '0;
            end else begin
                st[g+1].valid <= st[g].valid;
                if (!ys[XW-1]) begin
                    st[g+1].x <= xs + (ys >>> g);
                    st[g+1].y <= ys - (xs >>> g);
                    st[g+1].z <= st[g].z + ANG;
                end else begin
                    st[g+1].x <= xs - (ys >>> g);
                    st[g+1].y <= ys + (xs >>> g);
                    st[g+1].z <= st[g].z - ANG;
                end
            end
        end
    end

    assign res_valid = st[STAGES].valid;
    assign res_x     = st[STAGES].x;
    assign res_z     = st[STAGES].z;

endmodule

// File: rtl/polar_scale.sv
module polar_scale
    import polar_disc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  logic signed [XW-1:0] x_in,
    input  logic signed [AW-1:0] z_in,
    output logic                 v_out,
    output logic [DW-1:0]        mag_out,
    output logic [DW-1:0]        phase_out
);
    localparam int PW = XW + 16;
    localparam logic [PW-1:0] HALF_M = PW'(1) << (GUARD + 15);
    localparam logic signed [AW-1:0] HALF_Z = AW'(1) <<< (AW - DW - 1);

    logic [PW-1:0]        prod, rounded;
    logic [DW-1:0]        mag_c;
    logic signed [AW-1:0] zr;

    always_comb begin
        prod    = PW'($unsigned(x_in)) * PW'(INV_GAIN);
        rounded = prod + HALF_M;
        if ((rounded >> (GUARD + 16 + DW)) != '0) mag_c = '1;
        else                                      mag_c = DW'(rounded >> (GUARD + 16));
        zr = z_in + HALF_Z;   // wraps at +pi naturally
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out     <= 1'b0;
            mag_out   <= '0;
            phase_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                mag_out   <= mag_c;
                phase_out <= DW'(zr >>> (AW - DW));
            end
        end
    end

endmodule

// File: rtl/freq_disc.sv
module freq_disc
    import polar_disc_pkg::*;
#(
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ph_valid,
    input  logic [DW-1:0] ph,
    input  logic [KW-1:0] k,
    output logic          f_valid,
    output logic [DW-1:0] f
);
    localparam int FRAC = (1 << KW) - 1;
    localparam int SW   = DW + FRAC;
    localparam int EW   = SW + 3;

    logic [DW-1:0]        prev;
    logic                 have_prev;
    logic signed [SW-1:0] s;

    logic signed [DW-1:0] dlt;
    logic signed [EW-1:0] tgt, err, step, snext;

    always_comb begin
        dlt   = signed'(ph - prev);
        tgt   = EW'(dlt) <<< FRAC;
        err   = tgt - EW'(s);
        step  = err >>> k;
        snext = EW'(s) + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= '0;
            have_prev <= 1'b0;
            s         <= '0;
            f_valid   <= 1'b0;
            f         <= '0;
        end else begin
            f_valid <= ph_valid && have_prev;
            if (ph_valid) begin
                prev      <= ph;
                have_prev <= 1'b1;
                if (have_prev) begin
                    s <= SW'(snext);
                    f <= DW'(snext >>> FRAC);
                end
            end
        end
    end

    assert_freq_after_phase_R5: assert property (@(posedge clk) disable iff (rst)
        f_valid |-> $past(ph_valid));

    assert_first_phase_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        f_valid |-> $past(have_prev));

endmodule

// File: rtl/polar_disc.sv
module polar_disc
    import polar_disc_pkg::*;
#(
    parameter int STAGES = 16,
    parameter int KW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [15:0]   in_i,
    input  logic [15:0]   in_q,
    input  logic [KW-1:0] smooth_k,
    output logic          out_valid,
    output logic [15:0]   mag,
    output logic [15:0]   phase,
    output logic          freq_valid,
    output logic [15:0]   freq
);
    localparam int LAT = STAGES + 1;
    localparam int CW  = $clog2(LAT + 2) + 1;

    logic                 c_valid;
    logic signed [XW-1:0] c_x;
    logic signed [AW-1:0] c_z;

    cordic_vec #(.STAGES(STAGES)) u_cordic (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .res_valid(c_valid), .res_x(c_x), .res_z(c_z)
    );

    polar_scale u_scale (
        .clk(clk), .rst(rst), .v_in(c_valid), .x_in(c_x), .z_in(c_z),
        .v_out(out_valid), .mag_out(mag), .phase_out(phase)
    );

    freq_disc #(.KW(KW)) u_freq (
        .clk(clk), .rst(rst), .ph_valid(out_valid), .ph(phase), .k(smooth_k),
        .f_valid(freq_valid), .f(freq)
    );

    // samples accepted but not yet delivered (checking only)
    logic [CW-1:0] inflight;
    always_ff @(posedge clk) begin
        if (rst)                       inflight <= '0;
        else if (in_valid && !out_valid) inflight <= inflight + 1'b1;
        else if (!in_valid && out_valid) inflight <= inflight - 1'b1;
    end

    assert_result_has_source_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    assert_inflight_bound_R4: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(LAT + 1));

endmodule

// File: tb/polar_disc_tb_top.sv
`timescale 1ns/1ps
module polar_disc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic [2:0]  smooth_k = '0;
    logic        out_valid, freq_valid;
    logic [15:0] mag, phase, freq;

    always #10 clk = ~clk;   // 50 MHz

    polar_disc dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .smooth_k(smooth_k), .out_valid(out_valid), .mag(mag), .phase(phase),
        .freq_valid(freq_valid), .freq(freq)
    );

    typedef struct { int i; int q; longint due; bit quad; } exp_t;
    typedef struct { logic [15:0] f; longint due; int k; } fexp_t;
    exp_t  pq[$];
    fexp_t fq[$];

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int     checks = 0, fails = 0;
    int     n_sent = 0, n_out = 0, n_freq = 0;
    longint s_m = 0;
    logic [15:0] prev_m = '0;
    bit     have_m = 0;
    bit     done = 0;
    bit     quad_mode = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic send(input int i, input int q);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 16'(i);
        in_q = 16'(q);
        pq.push_back('{i, q, cyc + 18, quad_mode});
        n_sent++;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic tone(input int n, input real step, input real amp, input int gap_every);
        real th = 0.3;
        for (int j = 0; j < n; j++) begin
            send($rtoi(amp * $cos(th)), $rtoi(amp * $sin(th)));
            th = th + step;
            if (gap_every != 0 && (j % gap_every) == gap_every - 1) idle(1 + j % 4);
        end
    endtask

    // monitor: compares results against ideal values
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                n_out++;
                if (pq.size() == 0) begin
                    check(0, "R4", "result without sample", 1, 0);
                end else begin
                    exp_t e;
                    real  rm, ra;
                    int   ep;
                    shortint dphi;
                    e = pq.pop_front();
                    check(cyc == e.due, "R4", "result cycle", cyc, e.due);
                    rm = $sqrt(real'(e.i) * e.i + real'(e.q) * e.q);
                    check(($itor(mag) - rm) <= 3.0 && (rm - $itor(mag)) <= 3.0,
                          "R1", "magnitude", mag, $rtoi(rm + 0.5));
                    ra = $atan2(real'(e.q), real'(e.i)) / 3.14159265358979 * 32768.0;
                    ep = $rtoi(ra + (ra >= 0 ? 0.5 : -0.5));
                    dphi = shortint'(phase - 16'(ep));
                    check(dphi <= 3 && dphi >= -3, e.quad ? "R3" : "R2", "phase",
                          $signed(phase), ep);
                    if (have_m) begin
                        shortint dd;
                        dd  = shortint'(phase - prev_m);
                        s_m = s_m + (((longint'(dd)) * 128 - s_m) >>> smooth_k);
                        fq.push_back('{16'(s_m >>> 7), cyc + 1, int'(smooth_k)});
                    end
                    prev_m = phase;
                    have_m = 1;
                end
            end
            if (freq_valid) begin
                n_freq++;
                if (fq.size() == 0) begin
                    check(0, "R6", "unexpected frequency result", 1, 0);
                end else begin
                    fexp_t fe;
                    fe = fq.pop_front();
                    check(cyc == fe.due, "R5", "frequency cycle", cyc, fe.due);
                    check(freq == fe.f, fe.k == 0 ? "R5" : "R7", "frequency value",
                          $signed(freq), $signed(fe.f));
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R8: quiet and zero during reset
        check(!out_valid && !freq_valid, "R8", "valids in reset", {out_valid, freq_valid}, 0);
        check(mag == 0 && phase == 0 && freq == 0, "R8", "data in reset", mag | phase | freq, 0);
        have_m = 0;
        s_m = 0;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        do_reset();
        @(negedge clk);
        // R8: still quiet after release
        check(!out_valid && !freq_valid && mag == 0, "R8", "after release", mag, 0);

        // R3: quadrants, axes and full-scale corners, back to back
        quad_mode = 1;
        send(20000, 0);      send(0, 20000);      send(-20000, 0);
        send(0, -20000);     send(15000, 15000);  send(-15000, 15000);
        send(-15000, -15000); send(15000, -15000); send(32767, 32767);
        send(-32768, -32768); send(-32768, 0);    send(1000, -3000);
        send(-32768, 32767); send(-5000, 1);      send(-5000, -1);
        idle(30);
        quad_mode = 0;
        // R6: the first result after reset has no frequency partner
        check(n_freq == n_out - 1, "R6", "frequency count after reset", n_freq, n_out - 1);

        // R5: FM-like tone, k=0, positive then negative steps
        tone(40, 0.15, 20000.0, 0);
        tone(40, -0.9, 12000.0, 0);
        idle(30);

        // R9: gaps between samples, difference taken across gaps
        base = n_out;
        tone(30, 2.5, 25000.0, 3);
        idle(30);
        check(n_out - base == 30, "R9", "results with gaps", n_out - base, 30);

        // R7: smoothing with several shift values
        smooth_k = 3'd3;
        tone(50, 0.4, 18000.0, 0);
        idle(30);
        smooth_k = 3'd7;
        tone(40, -0.2, 18000.0, 5);
        idle(30);
        smooth_k = 3'd1;
        tone(30, 3.0, 9000.0, 0);
        idle(30);
        smooth_k = 3'd0;

        // R6: reset mid-run, first result again suppressed
        do_reset();
        base = n_freq;
        send(3000, 4000);
        idle(25);
        check(n_freq == base, "R6", "frequency after first result", n_freq - base, 0);
        send(-4000, 3000);
        idle(25);
        check(n_freq == base + 1, "R6", "frequency after second result", n_freq - base, 1);

        check(pq.size() == 0, "R4", "results outstanding", pq.size(), 0);
        check(fq.size() == 0, "R5", "frequency results outstanding", fq.size(), 0);
        check(n_out == n_sent, "R9", "result count", n_out, n_sent);
        finish_run();
    end

endmodule